// File: doc/BRIEF.md
# Multi-Master Bus Matrix Arbiter

This block sits between five bus masters and four slave ports and decides, cycle by cycle, which master owns each slave. The masters are a CPU operand port, a CPU instruction-fetch port, an Ethernet DMA engine, a general-purpose DMA engine and a transfer controller. The slaves are on-chip RAM, on-chip ROM, an external-space port and a peripheral port. Every slave has its own arbiter, so transfers to different slaves run side by side. A master that wins a slave keeps it until the slave signals completion.

Ranking is in two tiers. All non-CPU masters rank above the CPU. Within the non-CPU tier the Ethernet DMA comes first, the general DMA second and the transfer controller third. Within the CPU tier an operand access comes before an instruction fetch. Two exclusive modes narrow the set of masters that may win. An atomic-exchange lock admits only the CPU ports. A control-information lock admits only the transfer controller. The CPU's direct path into ROM is read-only: a CPU write aimed at ROM is answered with an error instead of a grant.

A master raises its request with the target address and write flag, holds them steady, and drops the request after it sees its acknowledge pulse. A slave sees its grant and a master-select code, and it raises its ready input on the cycle its transfer ends.

Top module: `mm_bus_matrix`

## Requirements
- R1: The target slave is taken from the top two address bits: 0 is RAM, 1 is ROM, 2 is external space and 3 is the peripheral port. The master index on all vectors and in the select code is: 0 Ethernet DMA, 1 general DMA, 2 transfer controller, 3 CPU operand, 4 CPU fetch.
- R2: When several eligible masters request one free slave, the lowest master index wins. The winner's slave asserts its grant, with the select field equal to that index, from the next clock edge.
- R3: Requests to different slaves are granted in the same cycle, each by its own slave's ranking.
- R4: A grant and its select value stay unchanged until a clock edge at which that slave's ready is high. That edge removes the grant, and the owning master's acknowledge is high for exactly the following cycle. The acknowledged master is not eligible during that cycle.
- R5: After reset every grant, acknowledge and error output is low.
- R6: The CPU lock becomes active when the CPU lock input is high together with a CPU request and no other lock is held. While it is active only masters 3 and 4 can win. It ends at the first edge at which the CPU lock input is low and no CPU port owns a slave.
- R7: The transfer-controller lock works like the CPU lock but admits only master 2. If both lock inputs qualify in the same cycle, this lock takes precedence.
- R8: A CPU port (master 3 or 4) with its write flag high that wins the ROM slave is not granted. Instead its acknowledge and error outputs are high together for one cycle, one edge after the winning cycle.
- R9: A request held back by a lock stays pending. It is granted in ranking order at the second clock edge after the lock input is dropped, provided the locking master owns no slave.
- R10: A master never owns more than one slave at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | 5 | Per-master request, held until acknowledged |
| m_addr | input | 5*ADDR_W | Per-master address, master m in slice m |
| m_write | input | 5 | Per-master write flag |
| cpu_xchg_lock | input | 1 | CPU atomic-exchange lock request |
| dtc_ctrl_lock | input | 1 | Transfer-controller control-information lock request |
| s_ready | input | N_S | Per-slave transfer-complete strobe |
| m_ack | output | 5 | Per-master one-cycle completion pulse |
| m_err | output | 5 | Per-master error pulse (ROM write on the CPU path) |
| s_grant | output | N_S | Per-slave grant |
| s_sel | output | N_S*3 | Per-slave index of the owning master |

## Verification
A grant appears one edge after the request is seen on a free slave. The acknowledge follows one edge after the edge that samples ready high, and an error pulse arrives one edge after the losing CPU ROM write. A request held by a lock is granted two edges after its lock input falls. The bench drives inputs on the falling edge, advances a behavioural model on the rising edge, and compares every output on the next falling edge, so each expected value is read in the cycle it becomes due. Directed sequences check these latencies with literal values, and a long random run covers the interplay between locks, ranking and slave readiness.

// File: rtl/mm_bm_pkg.sv
package mm_bm_pkg;
  localparam int NUM_M    = 5;
  localparam int M_ETH    = 0;
  localparam int M_DMA    = 1;
  localparam int M_DTC    = 2;
  localparam int M_CPU_OP = 3;
  localparam int M_CPU_IF = 4;
  localparam int S_ROM    = 1;

  typedef enum logic [1:0] {
    LK_NONE = 2'd0,
    LK_CPU  = 2'd1,
    LK_DTC  = 2'd2
  } lock_e;
endpackage

// File: rtl/mm_bm_lock.sv
module mm_bm_lock
  import mm_bm_pkg::*;
#(
  parameter int N_M = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N_M-1:0] m_req,
  input  logic [N_M-1:0] owned,
  input  logic           cpu_lock_in,
  input  logic           dtc_lock_in,
  output logic [N_M-1:0] elig,
  output lock_e          lock_q
);
  lock_e lk_eff, lk_nxt;
  logic  cpu_owns, dtc_owns;

  always_comb begin
    cpu_owns = owned[M_CPU_OP] | owned[M_CPU_IF];
    dtc_owns = owned[M_DTC];
    lk_eff   = lock_q;
    if (lock_q == LK_NONE) begin
      if (dtc_lock_in && m_req[M_DTC])
        lk_eff = LK_DTC;
      else if (cpu_lock_in && (m_req[M_CPU_OP] || m_req[M_CPU_IF]))
        lk_eff = LK_CPU;
    end
    for (int m = 0; m < N_M; m++) begin
      case (lk_eff)
        LK_CPU:  elig[m] = (m >= M_CPU_OP);
        LK_DTC:  elig[m] = (m == M_DTC);
        default: elig[m] = 1'b1;
      endcase
    end
    lk_nxt = lk_eff;
    if (lk_eff == LK_CPU && !cpu_lock_in && !cpu_owns) lk_nxt = LK_NONE;
    if (lk_eff == LK_DTC && !dtc_lock_in && !dtc_owns) lk_nxt = LK_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) lock_q <= LK_NONE;
    else     lock_q <= lk_nxt;
  end

  // R6: an active CPU lock persists while its input stays high
  p_lock_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (lock_q == LK_CPU && cpu_lock_in) |=> (lock_q == LK_CPU));
  // R7: an active controller lock persists while its input stays high
  p_lock_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (lock_q == LK_DTC && dtc_lock_in) |=> (lock_q == LK_DTC));
endmodule

// File: rtl/mm_bm_slave_arb.sv
module mm_bm_slave_arb
  import mm_bm_pkg::*;
#(
  parameter int N_M        = 5,
  parameter int MW         = 3,
  parameter bit BAR_CPU_WR = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N_M-1:0] cand,
  input  logic [N_M-1:0] wr,
  input  logic           s_ready,
  output logic           grant_q,
  output logic [MW-1:0]  sel_q,
  output logic [N_M-1:0] done,
  output logic [N_M-1:0] err
);
  logic          win_v;
  logic [MW-1:0] win_idx;
  logic          bar_hit;

  always_comb begin
    win_v   = 1'b0;
    win_idx = '0;
    for (int m = N_M - 1; m >= 0; m--) begin
      if (cand[m]) begin
        win_v   = 1'b1;
        win_idx = MW'(m);
      end
    end
  end

  generate
    if (BAR_CPU_WR) begin : g_bar
      assign bar_hit = win_v && (int'(win_idx) >= M_CPU_OP) && wr[win_idx];
    end else begin : g_nobar
      assign bar_hit = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= 1'b0;
      sel_q   <= '0;
    end else if (grant_q) begin
      if (s_ready) begin
        grant_q <= 1'b0;
        sel_q   <= '0;
      end
    end else if (win_v && !bar_hit) begin
      grant_q <= 1'b1;
      sel_q   <= win_idx;
    end
  end

  always_comb begin
    done = '0;
    err  = '0;
    if (grant_q && s_ready) done[sel_q] = 1'b1;
    if (!grant_q && bar_hit) begin
      done[win_idx] = 1'b1;
      err[win_idx]  = 1'b1;
    end
  end

  // R4: no change of owner while the transfer is open
  p_no_preempt_r4: assert property (@(posedge clk) disable iff (rst)
    (grant_q && !s_ready) |=> (grant_q && $stable(sel_q)));
  // R4: a completing transfer leaves the slave idle for one cycle
  p_release_r4: assert property (@(posedge clk) disable iff (rst)
    (grant_q && s_ready) |=> !grant_q);

  generate
    if (BAR_CPU_WR) begin : g_bar_chk
      // R8: a CPU write that wins ROM never becomes a grant
      p_rom_bar_r8: assert property (@(posedge clk) disable iff (rst)
        (!grant_q && win_v && int'(win_idx) >= M_CPU_OP && wr[win_idx]) |=> !grant_q);
    end
  endgenerate
endmodule

// File: rtl/mm_bus_matrix.sv
module mm_bus_matrix
  import mm_bm_pkg::*;
#(
  parameter int N_S    = 4,
  parameter int ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_M-1:0]      m_req,
  input  logic [NUM_M*ADDR_W-1:0] m_addr,
  input  logic [NUM_M-1:0]      m_write,
  input  logic                  cpu_xchg_lock,
  input  logic                  dtc_ctrl_lock,
  input  logic [N_S-1:0]        s_ready,
  output logic [NUM_M-1:0]      m_ack,
  output logic [NUM_M-1:0]      m_err,
  output logic [N_S-1:0]        s_grant,
  output logic [N_S*3-1:0]      s_sel
);
  localparam int N_M   = NUM_M;
  localparam int SEL_W = $clog2(N_S);
  localparam int MW    = 3;

  logic [SEL_W-1:0] tgt      [N_M];
  logic [N_M-1:0]   cand     [N_S];
  logic [N_M-1:0]   done_v   [N_S];
  logic [N_M-1:0]   err_v    [N_S];
  logic [N_S-1:0]   hold_map [N_M];
  logic [N_M-1:0]   owned, elig, ack_nxt, err_nxt;
  lock_e            lock_q;

  generate
    for (genvar m = 0; m < N_M; m++) begin : g_dec
      assign tgt[m] = m_addr[m*ADDR_W + ADDR_W - SEL_W +: SEL_W];
    end
  endgenerate

  always_comb begin
    owned = '0;
    for (int m = 0; m < N_M; m++) hold_map[m] = '0;
    for (int s = 0; s < N_S; s++) begin
      if (s_grant[s]) begin
        owned[s_sel[s*MW +: MW]]    = 1'b1;
        hold_map[s_sel[s*MW +: MW]][s] = 1'b1;
      end
    end
  end

  mm_bm_lock #(.N_M(N_M)) u_lock (
    .clk        (clk),
    .rst        (rst),
    .m_req      (m_req),
    .owned      (owned),
    .cpu_lock_in(cpu_xchg_lock),
    .dtc_lock_in(dtc_ctrl_lock),
    .elig       (elig),
    .lock_q     (lock_q)
  );

  always_comb begin
    for (int s = 0; s < N_S; s++) begin
      for (int m = 0; m < N_M; m++) begin
        cand[s][m] = m_req[m] && (tgt[m] == SEL_W'(s)) && !m_ack[m] && elig[m];
      end
    end
  end

  generate
    for (genvar s = 0; s < N_S; s++) begin : g_slv
      mm_bm_slave_arb #(
        .N_M       (N_M),
        .MW        (MW),
        .BAR_CPU_WR(s == S_ROM)
      ) u_arb (
        .clk    (clk),
        .rst    (rst),
        .cand   (cand[s]),
        .wr     (m_write),
        .s_ready(s_ready[s]),
        .grant_q(s_grant[s]),
        .sel_q  (s_sel[s*MW +: MW]),
        .done   (done_v[s]),
        .err    (err_v[s])
      );

      // R6: no non-CPU grant can start under the CPU lock
      p_cpu_lock_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(s_grant[s]) && lock_q == LK_CPU) |-> (int'(s_sel[s*MW +: MW]) >= M_CPU_OP));
      // R7: only the controller can start a grant under its lock
      p_dtc_lock_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(s_grant[s]) && lock_q == LK_DTC) |-> (int'(s_sel[s*MW +: MW]) == M_DTC));
    end
    for (genvar m = 0; m < N_M; m++) begin : g_own_chk
      // R10: one slave per master at most
      p_one_slave_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hold_map[m]));
    end
  endgenerate

  always_comb begin
    ack_nxt = '0;
    err_nxt = '0;
    for (int s = 0; s < N_S; s++) begin
      ack_nxt = ack_nxt | done_v[s];
      err_nxt = err_nxt | err_v[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_ack <= '0;
      m_err <= '0;
    end else begin
      m_ack <= ack_nxt;
      m_err <= err_nxt;
    end
  end

  // R8: an error always comes with its acknowledge
  p_err_ack_r8: assert property (@(posedge clk) disable iff (rst)
    ((m_err & ~m_ack) == '0));
  // R4: an acknowledge lasts a single cycle per transfer
  p_ack_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (m_ack != '0 && s_ready == '0) |=> ((m_ack & $past(m_ack)) == '0));
endmodule

// File: tb/mm_bus_matrix_tb_top.sv
module mm_bus_matrix_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 5;
  localparam int NS = 4;
  localparam int AW = 32;
  localparam int WATCHDOG = 100000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NM-1:0]   req = '0;
  logic [NM*AW-1:0] addr = '0;
  logic [NM-1:0]   wr = '0;
  logic            lk_cpu = 1'b0;
  logic            lk_dtc = 1'b0;
  logic [NS-1:0]   rdy = '0;
  logic [NM-1:0]   m_ack, m_err;
  logic [NS-1:0]   s_grant;
  logic [NS*3-1:0] s_sel;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit armed = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mm_bus_matrix #(.N_S(NS), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .m_req(req), .m_addr(addr), .m_write(wr),
    .cpu_xchg_lock(lk_cpu), .dtc_ctrl_lock(lk_dtc), .s_ready(rdy),
    .m_ack(m_ack), .m_err(m_err), .s_grant(s_grant), .s_sel(s_sel)
  );

  // reference model state: owner per slave (-1 idle), ack/err pulses, lock 0/1 cpu/2 dtc
  int      mo [NS];
  bit [NM-1:0] mack, merr;
  int      mlk;

  function automatic int tgt_of(int m);
    return int'(addr[m*AW + AW - 2 +: 2]);
  endfunction

  always @(posedge clk) begin
    int lk, win;
    bit own_c, own_d;
    bit [NM-1:0] el, nack, nerr;
    if (rst) begin
      for (int s = 0; s < NS; s++) mo[s] = -1;
      mack = '0; merr = '0; mlk = 0; armed = 1'b1;
    end else begin
      own_c = 1'b0; own_d = 1'b0;
      for (int s = 0; s < NS; s++) begin
        if (mo[s] >= 3) own_c = 1'b1;
        if (mo[s] == 2) own_d = 1'b1;
      end
      lk = mlk;
      if (lk == 0) begin
        if (lk_dtc && req[2]) lk = 2;
        else if (lk_cpu && (req[3] || req[4])) lk = 1;
      end
      for (int m = 0; m < NM; m++)
        el[m] = (lk == 0) || (lk == 1 && m >= 3) || (lk == 2 && m == 2);
      nack = '0; nerr = '0;
      for (int s = 0; s < NS; s++) begin
        if (mo[s] >= 0) begin
          if (rdy[s]) begin nack[mo[s]] = 1'b1; mo[s] = -1; end
        end else begin
          win = -1;
          for (int m = NM - 1; m >= 0; m--)
            if (req[m] && tgt_of(m) == s && !mack[m] && el[m]) win = m;
          if (win >= 0) begin
            if (s == 1 && win >= 3 && wr[win]) begin
              nack[win] = 1'b1; nerr[win] = 1'b1;
            end else mo[s] = win;
          end
        end
      end
      if (lk == 1 && !lk_cpu && !own_c) lk = 0;
      else if (lk == 2 && !lk_dtc && !own_d) lk = 0;
      mlk = lk; mack = nack; merr = nerr;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R1 R2 R3 R4 R6 R7 R8 R9)
  always @(negedge clk) begin
    if (armed) begin
      for (int s = 0; s < NS; s++) begin
        chk(s_grant[s] == (mo[s] >= 0), "R2 model grant", int'(s_grant[s]), int'(mo[s] >= 0));
        if (mo[s] >= 0)
          chk(int'(s_sel[s*3 +: 3]) == mo[s], "R1 model select", int'(s_sel[s*3 +: 3]), mo[s]);
      end
      chk(m_ack == mack, "R4 model ack", int'(m_ack), int'(mack));
      chk(m_err == merr, "R8 model err", int'(m_err), int'(merr));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic put(int m, int slv, bit w);
    addr[m*AW +: AW] = {slv[1:0], 30'($urandom)};
    wr[m]  = w;
    req[m] = 1'b1;
  endtask

  task automatic do_reset();
    rst = 1'b1; req = '0; wr = '0; rdy = '0; lk_cpu = 1'b0; lk_dtc = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic int sel_of(int s);
    return int'(s_sel[s*3 +: 3]);
  endfunction

  initial begin
    do_reset();
    // R5: reset state
    chk(s_grant == '0 && m_ack == '0 && m_err == '0, "R5 reset outputs",
        int'({s_grant, m_ack, m_err}), 0);

    // R2 ranking: all masters target RAM (slave 0)
    for (int m = 0; m < NM; m++) put(m, 0, 1'b0);
    @(negedge clk);
    chk(s_grant[0] && sel_of(0) == 0, "R2 eth wins first", sel_of(0), 0);
    repeat (2) @(negedge clk);
    chk(s_grant[0] && sel_of(0) == 0, "R4 grant held while not ready", sel_of(0), 0);
    rdy[0] = 1'b1;
    @(negedge clk);
    chk(m_ack == 5'b00001 && !s_grant[0], "R4 ack after ready", int'(m_ack), 1);
    req[0] = 1'b0;
    for (int k = 1; k < NM; k++) begin
      @(negedge clk);
      chk(s_grant[0] && sel_of(0) == k, "R2 next in rank", sel_of(0), k);
      @(negedge clk);
      chk(m_ack == NM'(1 << k), "R4 ack pulse", int'(m_ack), 1 << k);
      req[k] = 1'b0;
    end
    rdy = '0;

    // R3: fetch to ROM and operand to RAM together
    do_reset();
    put(4, 1, 1'b0); put(3, 0, 1'b0); put(1, 2, 1'b1);
    @(negedge clk);
    chk(s_grant == 4'b0111, "R3 parallel grants", int'(s_grant), 7);
    chk(sel_of(0) == 3 && sel_of(1) == 4 && sel_of(2) == 1, "R3 parallel selects",
        sel_of(1), 4);
    rdy = 4'b1111;
    @(negedge clk);
    req = '0; rdy = '0;

    // R8: CPU operand write into ROM
    do_reset();
    put(3, 1, 1'b1);
    @(negedge clk);
    chk(!s_grant[1] && m_ack[3] && m_err[3], "R8 rom write refused",
        int'({s_grant[1], m_ack[3], m_err[3]}), 3);
    req[3] = 1'b0;
    @(negedge clk);
    chk(m_err == '0 && s_grant == '0, "R8 error is one cycle", int'(m_err), 0);

    // R6 and R9: CPU lock holds off the Ethernet DMA
    do_reset();
    lk_cpu = 1'b1; put(3, 0, 1'b1); put(0, 2, 1'b0);
    @(negedge clk);
    chk(s_grant == 4'b0001 && sel_of(0) == 3, "R6 only cpu granted", int'(s_grant), 1);
    rdy[0] = 1'b1;
    @(negedge clk);
    chk(m_ack[3] && !s_grant[2], "R6 other held during lock", int'(s_grant[2]), 0);
    req[3] = 1'b0; lk_cpu = 1'b0; rdy[0] = 1'b0;
    @(negedge clk);
    chk(!s_grant[2], "R9 still held at release edge", int'(s_grant[2]), 0);
    @(negedge clk);
    chk(s_grant[2] && sel_of(2) == 0, "R9 held request granted", sel_of(2), 0);
    rdy[2] = 1'b1;
    @(negedge clk);
    req = '0; rdy = '0;

    // R7 and R9: controller lock over CPU and Ethernet DMA, both locks raised
    do_reset();
    lk_dtc = 1'b1; lk_cpu = 1'b1;
    put(2, 3, 1'b0); put(3, 0, 1'b0); put(0, 1, 1'b0);
    @(negedge clk);
    chk(s_grant == 4'b1000 && sel_of(3) == 2, "R7 only controller granted", int'(s_grant), 8);
    lk_cpu = 1'b0;
    rdy[3] = 1'b1;
    @(negedge clk);
    chk(m_ack[2] && s_grant == '0, "R7 others held", int'(s_grant), 0);
    req[2] = 1'b0; lk_dtc = 1'b0; rdy[3] = 1'b0;
    @(negedge clk);
    chk(s_grant == '0, "R9 held until lock clears", int'(s_grant), 0);
    @(negedge clk);
    chk(s_grant == 4'b0011 && sel_of(0) == 3 && sel_of(1) == 0, "R9 both granted after release",
        int'(s_grant), 3);
    rdy = 4'b1111;
    @(negedge clk);
    req = '0; rdy = '0;

    // random traffic against the model (R1 R2 R3 R4 R6 R7 R8 R10)
    do_reset();
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      for (int m = 0; m < NM; m++) begin
        if (req[m] && m_ack[m]) req[m] = 1'b0;
        else if (!req[m] && $urandom_range(3) == 0)
          put(m, int'($urandom_range(3)), 1'($urandom_range(1)));
      end
      rdy = NS'($urandom);
      if ($urandom_range(11) == 0) lk_cpu = ~lk_cpu;
      if ($urandom_range(11) == 0) lk_dtc = ~lk_dtc;
    end
    lk_cpu = 1'b0; lk_dtc = 1'b0; req = '0; rdy = '1;
    repeat (4) @(negedge clk);
    chk(s_grant == '0, "R4 idle after drain", int'(s_grant), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule